// File: doc/BRIEF.md
# Read-Modify-Write Parity Update Sequencer

The sequencer carries out one small write to a disk array whose parity is spread across columns. A command gives the data column to update, the column holding that stripe's parity, the stripe row, and the new data word. The sequencer does not read the whole stripe. It fetches only the old data word and the old parity word. It then stores the new data and a new parity equal to old parity XOR old data XOR new data. This keeps the stripe invariant intact: the parity of a row is the XOR of all its data words.

All physical traffic goes over one request port with a valid/ready handshake. Each request carries an operation bit, a column, a row and a write word. Read results come back on a separate response strobe. The block holds one command at a time. It raises a busy flag while the four operations are in flight and pulses done when the last write is taken. A command that names the same column for data and parity is refused with an error pulse and causes no disk traffic.

Top module: `rmw_parity_seq`

## Requirements
- R1: Out of reset, and whenever no command is in progress, `cmd_ready_o` is 1 and a command with `cmd_valid_i` high is accepted at the next rising edge.
- R2: The first request after acceptance is a read (`req_write_o`=0) of the data column at the command's row.
- R3: The second request is a read of the parity column at the same row, and it is issued only after the response to the first read has arrived.
- R4: The third request is a write (`req_write_o`=1) of the new data word to the data column at the same row, issued after the parity read response.
- R5: The fourth and last request writes old parity XOR old data XOR new data to the parity column at the same row.
- R6: While `req_valid_o` is high and `req_ready_i` is low, the request and all of its fields stay unchanged on the next cycle.
- R7: `busy_o` is 1 from the cycle after acceptance until the fourth request's handshake, and `cmd_ready_o` is 0 throughout, so commands offered meanwhile are never taken.
- R8: `done_o` is a single-cycle pulse in the cycle right after the fourth request's handshake, and `busy_o` is 0 in that cycle.
- R9: A command whose data column equals its parity column produces a one-cycle `err_o` pulse in the cycle after it is offered, leaves `busy_o` at 0, and issues no request.
- R10: `rsp_valid_i` is ignored except while a read response is awaited; a strobe with other data while a request is pending does not alter the computed parity.
- R11: After reset, `busy_o`, `req_valid_o`, `done_o` and `err_o` are 0.

Requirements R2 to R5 define the fixed order: read data, read parity, write data, write parity. No other order is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer idle, command can be taken |
| cmd_dcol_i | input | COL_W | Data column to update |
| cmd_pcol_i | input | COL_W | Parity column of the stripe |
| cmd_row_i | input | ROW_W | Stripe row |
| cmd_data_i | input | DATA_W | New data word |
| req_valid_o | output | 1 | Physical request valid |
| req_ready_i | input | 1 | Physical request taken |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_col_o | output | COL_W | Request column |
| req_row_o | output | ROW_W | Request row |
| req_wdata_o | output | DATA_W | Write word (0 on reads) |
| rsp_valid_i | input | 1 | Read response strobe |
| rsp_rdata_i | input | DATA_W | Read response word |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command completed pulse |
| err_o | output | 1 | Command rejected pulse |

## Verification
Some rules can be watched on every cycle at the ports, and the assertions cover these:
- a stalled request stays stable;
- done lasts one cycle and comes only right after an accepted write;
- busy rises only through an accepted command;
- an error pulse never overlaps busy or done.

Other behaviour depends on values across a whole command, and only the bench scenarios can show it:
- the order of the four operations and their columns and rows;
- that the parity arithmetic is right;
- that a spurious response strobe is ignored;
- that a command offered while busy is refused.

The bench runs these scenarios against a disk model that adds handshake stalls and response delays.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_DATA = 3'd1,
    ST_WT_DATA = 3'd2,
    ST_RD_PAR  = 3'd3,
    ST_WT_PAR  = 3'd4,
    ST_WR_DATA = 3'd5,
    ST_WR_PAR  = 3'd6
  } rmw_state_e;

  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } disk_op_e;
endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic       col_clash_i,
  input  logic       req_ready_i,
  input  logic       rsp_valid_i,
  output rmw_state_e state_o,
  output logic       cmd_ready_o,
  output logic       accept_o,
  output logic       req_valid_o,
  output logic       cap_rsp_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  rmw_state_e state_q, state_d;
  logic       hs, reject, done_q, err_q;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign accept_o    = cmd_valid_i && cmd_ready_o && !col_clash_i;
  assign reject      = cmd_valid_i && cmd_ready_o && col_clash_i;
  assign req_valid_o = (state_q == ST_RD_DATA) || (state_q == ST_RD_PAR) ||
                       (state_q == ST_WR_DATA) || (state_q == ST_WR_PAR);
  assign hs          = req_valid_o && req_ready_i;
  // responses only count while a read result is awaited
  assign cap_rsp_o   = rsp_valid_i && ((state_q == ST_WT_DATA) || (state_q == ST_WT_PAR));
  assign busy_o      = !cmd_ready_o;
  assign state_o     = state_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept_o)    state_d = ST_RD_DATA;
      ST_RD_DATA: if (hs)          state_d = ST_WT_DATA;
      ST_WT_DATA: if (rsp_valid_i) state_d = ST_RD_PAR;
      ST_RD_PAR:  if (hs)          state_d = ST_WT_PAR;
      ST_WT_PAR:  if (rsp_valid_i) state_d = ST_WR_DATA;
      ST_WR_DATA: if (hs)          state_d = ST_WR_PAR;
      ST_WR_PAR:  if (hs)          state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_WR_PAR) && hs;
      err_q   <= reject;
    end
  end

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_isolated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !done_o && !req_valid_o));
endmodule

// File: rtl/rmw_dpath.sv
module rmw_dpath
  import rmw_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COL_W  = 3,
  parameter int unsigned ROW_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rmw_state_e        state_i,
  input  logic              accept_i,
  input  logic              cap_rsp_i,
  input  logic [COL_W-1:0]  cmd_dcol_i,
  input  logic [COL_W-1:0]  cmd_pcol_i,
  input  logic [ROW_W-1:0]  cmd_row_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  output logic              req_write_o,
  output logic [COL_W-1:0]  req_col_o,
  output logic [ROW_W-1:0]  req_row_o,
  output logic [DATA_W-1:0] req_wdata_o
);
  logic [COL_W-1:0]  dcol_q, pcol_q;
  logic [ROW_W-1:0]  row_q;
  logic [DATA_W-1:0] ndata_q, acc_q;

  // acc starts as new data and folds in each read result -> new parity
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcol_q  <= '0;
      pcol_q  <= '0;
      row_q   <= '0;
      ndata_q <= '0;
      acc_q   <= '0;
    end else if (accept_i) begin
      dcol_q  <= cmd_dcol_i;
      pcol_q  <= cmd_pcol_i;
      row_q   <= cmd_row_i;
      ndata_q <= cmd_data_i;
      acc_q   <= cmd_data_i;
    end else if (cap_rsp_i) begin
      acc_q   <= acc_q ^ rsp_rdata_i;
    end
  end

  assign req_row_o = row_q;

  always_comb begin
    req_write_o = OP_RD;
    req_col_o   = dcol_q;
    req_wdata_o = '0;
    unique case (state_i)
      ST_RD_PAR: req_col_o = pcol_q;
      ST_WR_DATA: begin
        req_write_o = OP_WR;
        req_wdata_o = ndata_q;
      end
      ST_WR_PAR: begin
        req_write_o = OP_WR;
        req_col_o   = pcol_q;
        req_wdata_o = acc_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rmw_parity_seq.sv
module rmw_parity_seq
  import rmw_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COL_W  = 3,
  parameter int unsigned ROW_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [COL_W-1:0]  cmd_dcol_i,
  input  logic [COL_W-1:0]  cmd_pcol_i,
  input  logic [ROW_W-1:0]  cmd_row_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic [COL_W-1:0]  req_col_o,
  output logic [ROW_W-1:0]  req_row_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  rmw_state_e state;
  logic       accept, cap_rsp, col_clash;

  assign col_clash = (cmd_dcol_i == cmd_pcol_i);

  rmw_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .col_clash_i (col_clash),
    .req_ready_i (req_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .state_o     (state),
    .cmd_ready_o (cmd_ready_o),
    .accept_o    (accept),
    .req_valid_o (req_valid_o),
    .cap_rsp_o   (cap_rsp),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  rmw_dpath #(.DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W)) i_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .accept_i    (accept),
    .cap_rsp_i   (cap_rsp),
    .cmd_dcol_i  (cmd_dcol_i),
    .cmd_pcol_i  (cmd_pcol_i),
    .cmd_row_i   (cmd_row_i),
    .cmd_data_i  (cmd_data_i),
    .rsp_rdata_i (rsp_rdata_i),
    .req_write_o (req_write_o),
    .req_col_o   (req_col_o),
    .req_row_o   (req_row_o),
    .req_wdata_o (req_wdata_o)
  );

  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_write_o) &&
      $stable(req_col_o) && $stable(req_row_o) && $stable(req_wdata_o)));

  assert_busy_from_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i && cmd_ready_o));

  assert_done_after_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_valid_o && req_ready_i && req_write_o));
endmodule

// File: tb/test_rmw_parity_seq.sv
`timescale 1ns/1ps
module test_rmw_parity_seq;
  localparam int DW = 32;
  localparam int CW = 3;
  localparam int RW = 8;
  localparam int NC = 1 << CW;
  localparam int NR = 1 << RW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic          cmd_ready_o;
  logic [CW-1:0] cmd_dcol_i = '0, cmd_pcol_i = '0;
  logic [RW-1:0] cmd_row_i = '0;
  logic [DW-1:0] cmd_data_i = '0;
  logic          req_valid_o, req_write_o;
  logic          req_ready_i = 1'b0;
  logic [CW-1:0] req_col_o;
  logic [RW-1:0] req_row_o;
  logic [DW-1:0] req_wdata_o;
  logic          rsp_valid_i = 1'b0;
  logic [DW-1:0] rsp_rdata_i = '0;
  logic          busy_o, done_o, err_o;

  always #2.5 clk_i = ~clk_i;

  rmw_parity_seq #(.DATA_W(DW), .COL_W(CW), .ROW_W(RW)) i_rmw_parity_seq (.*);

  int n_chk = 0, n_bad = 0;
  bit summary_done = 0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  endtask

  // disk model
  logic [DW-1:0] mem [NC][NR];
  int  stall_cfg = 0, stall_left = 0, rsp_lat = 0, rsp_cnt = 0;
  bit  junk_en = 0, rsp_pend = 0, prev_stall = 0;
  logic [DW-1:0] rsp_data;
  int  hold_viol = 0;
  logic          p_wr;
  logic [CW-1:0] p_col;
  logic [RW-1:0] p_row;
  logic [DW-1:0] p_wd;
  int  log_n = 0;
  logic          lg_wr  [8];
  logic [CW-1:0] lg_col [8];
  logic [RW-1:0] lg_row [8];
  logic [DW-1:0] lg_wd  [8];

  always @(negedge clk_i) begin
    rsp_valid_i = 1'b0;
    if (rsp_pend) begin
      if (rsp_cnt == 0) begin
        rsp_valid_i = 1'b1;
        rsp_rdata_i = rsp_data;
        rsp_pend    = 0;
      end else rsp_cnt--;
    end
    if (prev_stall && !(req_valid_o && req_write_o == p_wr && req_col_o == p_col &&
                        req_row_o == p_row && req_wdata_o == p_wd))
      hold_viol++;
    prev_stall = 0;
    if (req_valid_o) begin
      if (stall_left > 0) begin
        req_ready_i = 1'b0;
        stall_left--;
      end else req_ready_i = 1'b1;
    end else req_ready_i = 1'b0;
    if (req_valid_o && req_ready_i) begin
      if (log_n < 8) begin
        lg_wr[log_n] = req_write_o; lg_col[log_n] = req_col_o;
        lg_row[log_n] = req_row_o;  lg_wd[log_n] = req_wdata_o;
      end
      log_n++;
      if (req_write_o) mem[req_col_o][req_row_o] = req_wdata_o;
      else begin
        rsp_pend = 1; rsp_cnt = rsp_lat; rsp_data = mem[req_col_o][req_row_o];
      end
      stall_left = stall_cfg;
    end else if (req_valid_o) begin
      prev_stall = 1;
      p_wr = req_write_o; p_col = req_col_o; p_row = req_row_o; p_wd = req_wdata_o;
      if (junk_en && !rsp_valid_i) begin
        rsp_valid_i = 1'b1;
        rsp_rdata_i = 32'hDEAD_BEEF;
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  task automatic t_reset();
    @(negedge clk_i);
    chk(busy_o == 0 && req_valid_o == 0 && done_o == 0 && err_o == 0, "R11 reset outputs",
        {28'd0, busy_o, req_valid_o, done_o, err_o}, 32'd0);
    chk(cmd_ready_o == 1, "R1 ready after reset", cmd_ready_o, 1);
  endtask

  task automatic t_write(input int d, input int p, input int row, input logic [DW-1:0] nd,
                         input int stall, input int lat, input bit junk, input bit decoy);
    logic [DW-1:0] od, op, exp_par;
    int cyc;
    bit seen_done;
    od = mem[d][row]; op = mem[p][row];
    exp_par = op ^ od ^ nd;
    stall_cfg = stall; stall_left = stall; rsp_lat = lat; junk_en = junk;
    hold_viol = 0; log_n = 0;
    @(negedge clk_i);
    chk(cmd_ready_o == 1, "R1 idle ready", cmd_ready_o, 1);
    cmd_valid_i = 1; cmd_dcol_i = CW'(d); cmd_pcol_i = CW'(p);
    cmd_row_i = RW'(row); cmd_data_i = nd;
    @(negedge clk_i);
    chk(busy_o == 1, "R7 busy after accept", busy_o, 1);
    if (decoy) begin
      cmd_dcol_i = CW'(p); cmd_pcol_i = CW'(d); cmd_data_i = ~nd;
    end else cmd_valid_i = 0;
    cyc = 0; seen_done = 0;
    while (!seen_done && cyc < 400) begin
      if (done_o) begin
        seen_done = 1;
        cmd_valid_i = 0;
        chk(busy_o == 0, "R8 busy low with done", busy_o, 0);
      end else begin
        chk(busy_o == 1 && cmd_ready_o == 0, "R7 busy holds, no ready",
            {30'd0, busy_o, cmd_ready_o}, 32'd2);
        @(negedge clk_i);
        cyc++;
      end
    end
    chk(seen_done, "R8 done seen", seen_done, 1);
    @(negedge clk_i);
    chk(done_o == 0, "R8 done one cycle", done_o, 0);
    repeat (3) @(negedge clk_i);
    chk(log_n == 4, "R7 exactly four requests", log_n, 4);
    chk(lg_wr[0] == 0 && lg_col[0] == CW'(d) && lg_row[0] == RW'(row), "R2 read data column",
        {lg_wr[0], lg_col[0], lg_row[0]}, {1'b0, CW'(d), RW'(row)});
    chk(lg_wr[1] == 0 && lg_col[1] == CW'(p) && lg_row[1] == RW'(row), "R3 read parity column",
        {lg_wr[1], lg_col[1], lg_row[1]}, {1'b0, CW'(p), RW'(row)});
    chk(lg_wr[2] == 1 && lg_col[2] == CW'(d) && lg_wd[2] == nd, "R4 write new data",
        lg_wd[2], nd);
    chk(lg_wr[3] == 1 && lg_col[3] == CW'(p) && lg_row[3] == RW'(row), "R5 parity write target",
        {lg_wr[3], lg_col[3], lg_row[3]}, {1'b1, CW'(p), RW'(row)});
    chk(lg_wd[3] == exp_par, junk ? "R10 parity unaffected by stray strobe" : "R5 new parity",
        lg_wd[3], exp_par);
    chk(hold_viol == 0, "R6 stalled request stable", hold_viol, 0);
    junk_en = 0;
  endtask

  task automatic t_clash(input int c, input int row);
    log_n = 0;
    @(negedge clk_i);
    cmd_valid_i = 1; cmd_dcol_i = CW'(c); cmd_pcol_i = CW'(c);
    cmd_row_i = RW'(row); cmd_data_i = 32'h1234_5678;
    @(negedge clk_i);
    cmd_valid_i = 0;
    chk(err_o == 1 && busy_o == 0, "R9 error pulse, not busy", {30'd0, err_o, busy_o}, 32'd2);
    @(negedge clk_i);
    chk(err_o == 0, "R9 error one cycle", err_o, 0);
    repeat (4) @(negedge clk_i);
    chk(log_n == 0 && req_valid_o == 0, "R9 no disk request", log_n, 0);
  endtask

  initial begin
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++)
        mem[c][r] = (32'h0101_0101 * c) ^ (32'h9E37_79B9 * r) ^ 32'hA5A5_0F0F;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    t_reset();
    t_write(1, 4, 10, 32'hCAFE_F00D, 0, 0, 0, 0);
    t_write(6, 2, 200, 32'h0000_0001, 2, 3, 0, 0);
    t_write(0, 7, 10, 32'hFFFF_FFFF, 3, 1, 1, 0);
    t_write(3, 4, 10, 32'h5555_AAAA, 1, 2, 0, 1);
    t_write(1, 4, 10, 32'h0000_0000, 0, 4, 0, 0);
    t_clash(5, 3);
    t_write(7, 0, 255, 32'h8000_0000, 0, 0, 1, 1);
    finish_run();
  end
endmodule